// File: doc/BRIEF.md
# Per-Device Serial Clock and Chip-Select Sequencer

This block keeps one timing word for each of up to eight serial targets. When a transfer engine asks it to start, it produces the serial bit-clock edge strobe and the chip-select timing for the chosen target. The word sets four things: a rate field that scales the input clock by a power of two over 512, the number of cycles chip select leads the first clock edge, the number of cycles it stays asserted after the final bit, and the number of idle cycles it must stay released before the next transfer. The edge strobes come from a 9-bit phase accumulator. Each cycle the rate field is added to it, and each carry out is one edge.

Software writes the words through a plain address, data and write-enable port. The transfer engine drives a device index, a one-cycle `start` pulse and a `last_bit` level. `start` is a request and `ready` is its grant: a start is taken only in a cycle where `ready` is high, and a start in any other cycle is dropped without effect. Nothing at the edge of the block is held back or queued. The engine owns the shift datapath and the pin drivers. It sees bit-clock edges only as `edge_stb` pulses and sees chip select only as the `cs_active` level and the `cs_done` marker. When a transfer is accepted, the block takes a copy of the selected word. A write to the table therefore changes only transfers that start after the write.

Top module: `sclk_cs_sequencer`

## Requirements
- R1: After reset, `ready` is 1 and `cs_active`, `cs_done` and `edge_stb` are 0.
- R2: The word of device d is written at byte address 4*d. Address bits [1:0] are ignored. Each word is split into four fields: [31:24] rate, [23:16] setup, [15:8] hold, [7:0] gap.
- R3: A `start` seen while `ready` is 1 is accepted. In the next cycle `cs_active` is 1 and `cs_dev` equals the sampled `dev_sel`, and `cs_dev` stays fixed while `cs_active` is 1. A `start` seen while `ready` is 0 is ignored.
- R4: Count the first cycle in which `cs_active` is high as cycle 1. The first `edge_stb` then falls in cycle setup + 512/rate.
- R5: While bits are running, consecutive `edge_stb` pulses are exactly 512/rate cycles apart. A rate of 128 gives an edge every 4 cycles, and a rate of 1 gives an edge every 512 cycles.
- R6: A rate field of zero, or one that is not a power of two, behaves as a rate of 1.
- R7: `last_bit` high in a running cycle ends the bit phase. After that cycle there are no more `edge_stb` pulses. `cs_active` stays high for exactly hold more cycles, and `cs_done` is high only in the final cycle in which `cs_active` is high.
- R8: After `cs_active` falls, `ready` stays 0 for exactly gap cycles and then returns to 1. `ready` and `cs_active` are never high together.
- R9: A table write made during a transfer does not change that transfer. It does take effect from the next accepted start.
- R10: Each device keeps its own word. Writing one device leaves every other device's timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all timing is counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | 5 | Byte address of the word (device index in bits [4:2]) |
| cfg_wdata | input | 32 | Word to write |
| dev_sel | input | 3 | Target index for the next start |
| start | input | 1 | Transfer request, taken when `ready` is 1 |
| last_bit | input | 1 | Level from the engine marking the final bit cycle |
| edge_stb | output | 1 | One-cycle serial clock edge strobe |
| cs_active | output | 1 | Chip select of `cs_dev` is asserted |
| cs_done | output | 1 | Last cycle of chip-select assertion |
| cs_dev | output | 3 | Index of the target being served |
| ready | output | 1 | Idle and free to accept a start |

## Verification
A fault in the setup or hold counters shows at the ports as a first edge or a chip-select release that lands too early or too late, and the error is visible within one transfer. A fault in the phase accumulator shows as a wrong spacing between consecutive `edge_stb` pulses, measured from the second pulse onward. If the copy taken at start were skipped or taken at the wrong moment, a mid-transfer table write would change the spacing or the hold length of that same transfer. The directed tests write to the table while a transfer is running and compare the timing against the old word, so this fault appears within a few pulses.

// File: rtl/sclk_cs_pkg.sv
package sclk_cs_pkg;
  localparam int FIELD_W   = 8;
  localparam int SCALE_LOG = 9;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_RUN, ST_HOLD, ST_GAP
  } seq_state_e;

  typedef struct packed {
    logic [FIELD_W-1:0] rate;
    logic [FIELD_W-1:0] setup;
    logic [FIELD_W-1:0] hold;
    logic [FIELD_W-1:0] gap;
  } dev_word_t;

  function automatic logic [FIELD_W-1:0] legal_rate(input logic [FIELD_W-1:0] f);
    if (f == '0 || (f & (f - 1'b1)) != '0) return FIELD_W'(1);
    return f;
  endfunction
endpackage

// File: rtl/sclk_param_bank.sv
module sclk_param_bank
  import sclk_cs_pkg::*;
#(
  parameter int NDEV = 8,
  localparam int IDXW = (NDEV > 1) ? $clog2(NDEV) : 1,
  localparam int AW   = IDXW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [31:0]     wdata,
  input  logic [IDXW-1:0] rd_idx,
  output dev_word_t       rd_word
);
  dev_word_t words [NDEV];
  logic [IDXW-1:0] wr_idx;
  logic [1:0] unused_lsb;

  assign wr_idx     = addr[AW-1:2];
  assign unused_lsb = addr[1:0];

  for (genvar g = 0; g < NDEV; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) words[g] <= '0;
      else if (we && wr_idx == IDXW'(g)) words[g] <= dev_word_t'(wdata);
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NDEV; i++)
      if (rd_idx == IDXW'(i)) rd_word = words[i];
  end
endmodule

// File: rtl/sclk_phase_acc.sv
module sclk_phase_acc
  import sclk_cs_pkg::*;
#(
  parameter int ACC_W = SCALE_LOG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [FIELD_W-1:0] step,
  output logic               strobe
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  assign sum    = {1'b0, acc} + (ACC_W+1)'(step);
  assign strobe = run && sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n || !run) acc <= '0;
    else acc <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/sclk_cs_fsm.sv
module sclk_cs_fsm
  import sclk_cs_pkg::*;
#(
  parameter int IDXW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               last_bit,
  input  logic [IDXW-1:0]    dev_sel,
  input  dev_word_t          sel_word,
  output logic               run,
  output logic [FIELD_W-1:0] cur_rate,
  output logic               cs_active,
  output logic               cs_done,
  output logic [IDXW-1:0]    cur_dev,
  output logic               ready
);
  seq_state_e         state;
  dev_word_t          cur;
  logic [FIELD_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      cur     <= '0;
      cur_dev <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          cur      <= sel_word;
          cur.rate <= legal_rate(sel_word.rate);
          cur_dev  <= dev_sel;
          if (sel_word.setup != '0) begin
            state <= ST_SETUP;
            cnt   <= sel_word.setup;
          end else begin
            state <= ST_RUN;
          end
        end
        ST_SETUP: if (cnt == FIELD_W'(1)) state <= ST_RUN;
                  else cnt <= cnt - 1'b1;
        ST_RUN: if (last_bit) begin
          if (cur.hold != '0) begin
            state <= ST_HOLD;
            cnt   <= cur.hold;
          end else if (cur.gap != '0) begin
            state <= ST_GAP;
            cnt   <= cur.gap;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_HOLD: if (cnt == FIELD_W'(1)) begin
          if (cur.gap != '0) begin
            state <= ST_GAP;
            cnt   <= cur.gap;
          end else begin
            state <= ST_IDLE;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
        ST_GAP: if (cnt == FIELD_W'(1)) state <= ST_IDLE;
                else cnt <= cnt - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign run       = (state == ST_RUN);
  assign cur_rate  = cur.rate;
  assign ready     = (state == ST_IDLE);
  assign cs_active = (state == ST_SETUP) || (state == ST_RUN) || (state == ST_HOLD);
  assign cs_done   = (run && last_bit && cur.hold == '0)
                  || (state == ST_HOLD && cnt == FIELD_W'(1));
endmodule

// File: rtl/sclk_cs_sequencer.sv
module sclk_cs_sequencer
  import sclk_cs_pkg::*;
#(
  parameter int NDEV = 8,
  localparam int IDXW = (NDEV > 1) ? $clog2(NDEV) : 1,
  localparam int AW   = IDXW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [31:0]     cfg_wdata,
  input  logic [IDXW-1:0] dev_sel,
  input  logic            start,
  input  logic            last_bit,
  output logic            edge_stb,
  output logic            cs_active,
  output logic            cs_done,
  output logic [IDXW-1:0] cs_dev,
  output logic            ready
);
  dev_word_t          sel_word;
  logic               run;
  logic [FIELD_W-1:0] cur_rate;

  sclk_param_bank #(.NDEV(NDEV)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rd_idx(dev_sel), .rd_word(sel_word)
  );

  sclk_cs_fsm #(.IDXW(IDXW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .last_bit(last_bit),
    .dev_sel(dev_sel), .sel_word(sel_word), .run(run), .cur_rate(cur_rate),
    .cs_active(cs_active), .cs_done(cs_done), .cur_dev(cs_dev), .ready(ready)
  );

  sclk_phase_acc u_acc (
    .clk(clk), .rst_n(rst_n), .run(run), .step(cur_rate), .strobe(edge_stb)
  );
endmodule

// File: rtl/sclk_cs_sequencer_chk.sv
module sclk_cs_sequencer_chk #(
  parameter int IDXW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            ready,
  input logic            cs_active,
  input logic            cs_done,
  input logic            edge_stb,
  input logic [IDXW-1:0] cs_dev
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> ready && !cs_active);

  assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start && ready |=> cs_active);

  assert_dev_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_active && $past(cs_active) |-> $stable(cs_dev));

  assert_edge_inside_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_stb |-> cs_active);

  assert_done_before_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_active) |-> $past(cs_done));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_done |=> !cs_done && !cs_active);

  assert_ready_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && cs_active));
endmodule

bind sclk_cs_sequencer sclk_cs_sequencer_chk #(.IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .cs_active(cs_active),
  .cs_done(cs_done), .edge_stb(edge_stb), .cs_dev(cs_dev)
);

// File: tb/sclk_cs_sequencer_tb.sv
module sclk_cs_sequencer_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  dev_sel = '0;
  logic        start = 0;
  logic        last_bit = 0;
  logic        edge_stb, cs_active, cs_done, ready;
  logic [2:0]  cs_dev;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sclk_cs_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .dev_sel(dev_sel), .start(start), .last_bit(last_bit),
    .edge_stb(edge_stb), .cs_active(cs_active), .cs_done(cs_done),
    .cs_dev(cs_dev), .ready(ready)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkw(input int rate, input int su, input int hd, input int gp);
    return {rate[7:0], su[7:0], hd[7:0], gp[7:0]};
  endfunction

  task automatic write_word(input int addr, input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1; cfg_addr = addr[4:0]; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // One transfer: per = expected edge spacing, inj = write a new word mid-transfer,
  // poke = issue a stray start while busy.
  task automatic run_xfer(input int dev, input int per, input int su, input int hd,
                          input int gp, input int edges, input bit inj,
                          input logic [31:0] inj_word, input bit poke, input string tag);
    int n, seen, first, last, bad_sp, m, g, bad_e;
    @(negedge clk);
    check(ready == 1, "R3", {tag, " ready before start"}, int'(ready), 1);
    dev_sel = dev[2:0]; start = 1;
    @(negedge clk);
    start = 0;
    check(cs_active == 1, "R3", {tag, " cs after accept"}, int'(cs_active), 1);
    check(cs_dev == dev[2:0], "R3", {tag, " cs_dev"}, int'(cs_dev), dev);
    n = 1; seen = 0; first = 0; last = 0; bad_sp = 0;
    while (seen < edges && n < 4000) begin
      cfg_we = 0; start = 0;
      if (inj && n == 1) begin
        cfg_we = 1; cfg_addr = 5'(dev * 4); cfg_wdata = inj_word;
      end
      if (poke && n == 2) begin
        start = 1; dev_sel = 3'(dev + 1);
      end
      if (edge_stb) begin
        seen++;
        if (seen == 1) first = n;
        else if (n - last != per) bad_sp++;
        last = n;
        if (seen == edges) begin
          last_bit = 1;
          #1;
          check(cs_done == (hd == 0), "R7", {tag, " cs_done at last bit"}, int'(cs_done), int'(hd == 0));
          check(cs_dev == dev[2:0], "R3", {tag, " cs_dev held"}, int'(cs_dev), dev);
        end
      end
      if (seen < edges) begin
        @(negedge clk);
        n++;
      end
    end
    cfg_we = 0; start = 0;
    check(first == su + per, "R4", {tag, " first edge cycle"}, first, su + per);
    check(bad_sp == 0, "R5", {tag, " edge spacing errors"}, bad_sp, 0);
    @(negedge clk);
    last_bit = 0;
    m = 0; bad_e = 0;
    while (cs_active && m < 1000) begin
      if (edge_stb) bad_e++;
      if (cs_done != (m == hd - 1)) bad_e++;
      m++;
      @(negedge clk);
    end
    check(m == hd, "R7", {tag, " hold cycles"}, m, hd);
    check(bad_e == 0, "R7", {tag, " edges or done misplaced in hold"}, bad_e, 0);
    g = 0;
    while (!ready && g < 1000) begin
      g++;
      @(negedge clk);
    end
    check(g == gp, "R8", {tag, " gap cycles"}, g, gp);
    if (poke) begin
      repeat (3) begin
        check(cs_active == 0 && ready == 1, "R3", {tag, " stray start ignored"}, int'(cs_active), 0);
        @(negedge clk);
      end
    end
  endtask

  task automatic t_reset();
    check(ready == 1, "R1", "ready after reset", int'(ready), 1);
    check(cs_active == 0, "R1", "cs_active after reset", int'(cs_active), 0);
    check(edge_stb == 0 && cs_done == 0, "R1", "strobes after reset", int'(edge_stb), 0);
  endtask

  task automatic t_basic();
    write_word(0, mkw(128, 3, 2, 4));
    run_xfer(0, 4, 3, 2, 4, 3, 0, '0, 0, "R2/R5 rate128 dev0");
    write_word(5 * 4, mkw(32, 0, 0, 0));
    run_xfer(5, 16, 0, 0, 0, 2, 0, '0, 0, "R4 zero timing dev5");
  endtask

  task automatic t_sanitize();
    write_word(2 * 4, mkw(0, 1, 1, 1));
    run_xfer(2, 512, 1, 1, 1, 1, 0, '0, 0, "R6 rate zero");
    write_word(3 * 4, mkw(8'h30, 0, 1, 0));
    run_xfer(3, 512, 0, 1, 0, 2, 0, '0, 0, "R6 rate not pow2");
  endtask

  task automatic t_snapshot();
    write_word(1 * 4, mkw(64, 2, 1, 1));
    run_xfer(1, 8, 2, 1, 1, 2, 1, mkw(8, 5, 3, 3), 0, "R9 old word kept");
    run_xfer(1, 64, 5, 3, 3, 2, 0, '0, 0, "R9 new word used");
  endtask

  task automatic t_poke();
    write_word(4 * 4, mkw(16, 1, 2, 2));
    run_xfer(4, 32, 1, 2, 2, 2, 0, '0, 1, "R3 busy start");
  endtask

  task automatic t_addr_lsb();
    write_word(6 * 4 + 3, mkw(4, 0, 0, 2));
    run_xfer(6, 128, 0, 0, 2, 2, 0, '0, 0, "R2 addr lsb ignored");
    run_xfer(0, 4, 3, 2, 4, 2, 0, '0, 0, "R10 dev0 untouched");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_sanitize();
    t_snapshot();
    t_poke();
    t_addr_lsb();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule